// File: doc/BRIEF.md
# T1 Transmit Loopback Code Inserter

This block sits in the serial transmit path of a T1 framer, one bit slot per clock enable. In normal operation it forwards the outgoing bit stream unchanged. When software sets one of two control inputs, it replaces every payload bit with a repeating in-band loopback pattern. One input selects the activate (loop-up) pattern and the other selects the release (loop-down) pattern. Framing bit slots, flagged by a strobe from the framer, always carry the framer's own bit.

The pattern position advances only on payload slots. It therefore holds still across each framing slot and carries on from the same point after it. Enabling a pattern, or switching from one pattern to the other, restarts the pattern at its first bit. Setting both controls together is an illegal configuration. In that case the block forwards the stream unchanged and raises an error flag.

Top module: `t1_loop_inserter`

## Requirements
- R1: With only `loop_up_en` high, each payload slot carries the loop-up pattern, which repeats every 5 payload slots as a 1 followed by four 0s.
- R2: With only `loop_dn_en` high, each payload slot carries the loop-down pattern, which repeats every 3 payload slots as a 1 followed by two 0s.
- R3: In a slot where `frm_slot` is high, `tx_out` carries `tx_in` whatever the control inputs are.
- R4: With both controls low, `tx_out` carries `tx_in`. Clearing a control returns the very next slot to pass-through.
- R5: `cfg_err` is registered. On each clock it becomes 1 if both controls were high on that edge, and 0 otherwise.
- R6: With both controls high, `tx_out` carries `tx_in` in every slot.
- R7: A framing slot does not advance the pattern. The next payload slot continues the pattern from where it stopped.
- R8: The first slot in which a pattern is selected uses pattern position 0. This holds after pass-through, after the illegal state, and after a switch from the other pattern.
- R9: `tx_out` changes only on a clock edge where `bit_en` is high. The value for a slot appears on the clock after that edge.
- R10: While `rst_n` is low at a clock edge, `tx_out` and `cfg_err` go to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One pulse per transmitted bit slot |
| tx_in | input | 1 | Serial transmit bit from the framer |
| frm_slot | input | 1 | High when the current slot is a framing bit |
| loop_up_en | input | 1 | Select the loop-up pattern |
| loop_dn_en | input | 1 | Select the loop-down pattern |
| tx_out | output | 1 | Serial transmit bit after pattern insertion |
| cfg_err | output | 1 | Both controls set (illegal) |

## Verification
A wrong pattern position or a stale record of the selected pattern shows at `tx_out` within one pattern period. A misplaced 1 appears in the first payload slot whose position differs: the second payload slot after enabling for a missed restart, or the slot just after a framing bit for a counter that advanced when it should have paused. A reference model therefore compares `tx_out` and `cfg_err` with the expected values on every clock. The stimulus uses gapped and back-to-back slot enables and puts framing strobes inside patterns. It also covers direct switches between the two patterns and passes through the illegal state.

// File: rtl/lc_pkg.sv
// Shared types for the loop code inserter.
// Assumes: the two control inputs are static for a slot.
package lc_pkg;
    typedef enum logic [1:0] {
        LC_OFF = 2'd0,
        LC_UP  = 2'd1,
        LC_DN  = 2'd2,
        LC_BAD = 2'd3
    } lc_mode_t;
endpackage

// File: rtl/lc_mode_decode.sv
// Decodes the two control inputs into a single mode.
// Assumes: both inputs are synchronous to clk.
module lc_mode_decode
    import lc_pkg::*;
(
    input  logic     up_req,
    input  logic     dn_req,
    output lc_mode_t mode
);
    // Combine the two requests into one mode value
    always_comb begin
        unique case ({up_req, dn_req})
            2'b10:   mode = LC_UP;
            2'b01:   mode = LC_DN;
            2'b11:   mode = LC_BAD;
            default: mode = LC_OFF;
        endcase
    end
endmodule

// File: rtl/lc_phase_gen.sv
// Tracks the pattern position over payload slots only and produces the pattern bit.
// Assumes: the position is consumed only on slots where bit_en is high.
// Restarts at position 0 whenever the active mode differs from the mode of the
// previous slot.
module lc_phase_gen
    import lc_pkg::*;
#(
    parameter int UP_LEN = 5,
    parameter int DN_LEN = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_en,
    input  logic     frm_slot,
    input  lc_mode_t mode,
    output logic     code_active,
    output logic     code_bit
);
    localparam int MAX_LEN = (UP_LEN > DN_LEN) ? UP_LEN : DN_LEN;
    localparam int PW      = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] phase_cur;
    logic [PW-1:0] last_pos;
    lc_mode_t      prev_mode;
    logic          restart;

    // Only one of the two patterns may be active at a time
    assign code_active = (mode == LC_UP) || (mode == LC_DN);

    // A change of mode restarts the pattern at position 0
    assign restart   = (mode != prev_mode);
    assign phase_cur = restart ? '0 : phase_q;

    // Last position of the selected pattern
    generate
        if (UP_LEN == DN_LEN) begin : g_same_len
            assign last_pos = PW'(UP_LEN - 1);
        end else begin : g_diff_len
            assign last_pos = (mode == LC_UP) ? PW'(UP_LEN - 1) : PW'(DN_LEN - 1);
        end
    endgenerate

    // Both patterns put their single 1 at position 0
    assign code_bit = code_active && (phase_cur == '0);

    // Advance on payload slots, hold on framing slots, clear when idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= '0;
            prev_mode <= LC_OFF;
        end else if (bit_en) begin
            prev_mode <= mode;
            if (!code_active) begin
                phase_q <= '0;
            end else if (frm_slot) begin
                phase_q <= phase_cur;
            end else if (phase_cur == last_pos) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_cur + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lc_out_stage.sv
// Output register: selects the pattern bit or the incoming bit, and registers the error flag.
// Assumes: code_active already excludes the illegal mode.
module lc_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic tx_in,
    input  logic frm_slot,
    input  logic code_active,
    input  logic code_bit,
    input  logic illegal,
    output logic tx_out,
    output logic cfg_err
);
    logic next_bit;

    // Framing slots and inactive modes pass the incoming bit
    assign next_bit = (code_active && !frm_slot) ? code_bit : tx_in;

    // Register one output bit per slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_out <= 1'b0;
        end else if (bit_en) begin
            tx_out <= next_bit;
        end
    end

    // Register the illegal-configuration flag every clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= illegal;
        end
    end
endmodule

// File: rtl/t1_loop_inserter.sv
// Top level: inserts the repeating loop-up or loop-down pattern on payload slots.
// Assumes: the framer asserts frm_slot together with bit_en on framing slots.
module t1_loop_inserter
    import lc_pkg::*;
#(
    parameter int UP_LEN = 5,
    parameter int DN_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic tx_in,
    input  logic frm_slot,
    input  logic loop_up_en,
    input  logic loop_dn_en,
    output logic tx_out,
    output logic cfg_err
);
    lc_mode_t mode;
    logic     code_active;
    logic     code_bit;

    lc_mode_decode u_dec (
        .up_req (loop_up_en),
        .dn_req (loop_dn_en),
        .mode   (mode)
    );

    lc_phase_gen #(
        .UP_LEN (UP_LEN),
        .DN_LEN (DN_LEN)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .frm_slot    (frm_slot),
        .mode        (mode),
        .code_active (code_active),
        .code_bit    (code_bit)
    );

    lc_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .tx_in       (tx_in),
        .frm_slot    (frm_slot),
        .code_active (code_active),
        .code_bit    (code_bit),
        .illegal     (mode == LC_BAD),
        .tx_out      (tx_out),
        .cfg_err     (cfg_err)
    );
endmodule

// File: rtl/t1_loop_inserter_chk.sv
// Port-level checker for the loop code inserter, attached with bind.
module t1_loop_inserter_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic tx_in,
    input logic frm_slot,
    input logic loop_up_en,
    input logic loop_dn_en,
    input logic tx_out,
    input logic cfg_err
);
    // R9: the output holds between slots
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_out));

    // R3: framing slots pass the incoming bit
    p_frame_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frm_slot) |=> (tx_out == $past(tx_in)));

    // R4: both controls low pass the incoming bit
    p_idle_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !loop_up_en && !loop_dn_en) |=> (tx_out == $past(tx_in)));

    // R6: illegal setting passes the incoming bit
    p_illegal_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && loop_up_en && loop_dn_en) |=> (tx_out == $past(tx_in)));

    // R5: the error flag follows the controls one clock later
    p_err_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_up_en && loop_dn_en) |=> cfg_err);
    p_err_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(loop_up_en && loop_dn_en) |=> !cfg_err);

    // R10: reset clears both outputs
    p_reset_r10: assert property (@(posedge clk)
        !rst_n |=> (!tx_out && !cfg_err));
endmodule

bind t1_loop_inserter t1_loop_inserter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .tx_in      (tx_in),
    .frm_slot   (frm_slot),
    .loop_up_en (loop_up_en),
    .loop_dn_en (loop_dn_en),
    .tx_out     (tx_out),
    .cfg_err    (cfg_err)
);

// File: tb/tb_t1_loop_inserter.sv
// Bench: a behavioural reference model, compared with the outputs on every clock.
module tb_t1_loop_inserter;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic tx_in = 1'b0;
    logic frm_slot = 1'b0;
    logic loop_up_en = 1'b0;
    logic loop_dn_en = 1'b0;
    logic tx_out;
    logic cfg_err;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model state
    int  slot_cnt = 0;
    int  m_prev = 0;
    int  m_pos = 0;
    bit  exp_out = 1'b0;
    bit  exp_err = 1'b0;
    string tag = "R10";
    bit  in_reset = 1'b1;

    always #10 clk = ~clk;

    t1_loop_inserter dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_in(tx_in),
        .frm_slot(frm_slot), .loop_up_en(loop_up_en), .loop_dn_en(loop_dn_en),
        .tx_out(tx_out), .cfg_err(cfg_err)
    );

    // Reference model: update the expected outputs at each edge
    always @(posedge clk) begin
        int m;
        if (!rst_n) begin
            exp_out = 1'b0; exp_err = 1'b0; m_prev = 0; m_pos = 0;
            tag = "R10"; in_reset = 1'b1;
        end else begin
            in_reset = 1'b0;
            exp_err = loop_up_en && loop_dn_en;
            if (bit_en) begin
                if (loop_up_en && !loop_dn_en) m = 1;
                else if (loop_dn_en && !loop_up_en) m = 2;
                else m = (loop_up_en && loop_dn_en) ? 3 : 0;
                if (m != m_prev) m_pos = 0;
                if ((m == 1 || m == 2) && !frm_slot) begin
                    exp_out = (m_pos == 0);
                    m_pos = (m_pos + 1) % ((m == 1) ? 5 : 3);
                    tag = (m == 1) ? "R1/R7/R8" : "R2/R7/R8";
                end else begin
                    exp_out = tx_in;
                    if (frm_slot) tag = "R3";
                    else tag = (m == 3) ? "R6" : "R4";
                end
                m_prev = m;
            end else begin
                tag = "R9";
            end
        end
    end

    // Compare both outputs away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (tx_out !== exp_out) begin
                fails++;
                $display("FAIL %s tx_out actual=%b expected=%b at %0t", tag, tx_out, exp_out, $time);
            end
            checks++;
            if (cfg_err !== exp_err) begin
                fails++;
                $display("FAIL %s cfg_err actual=%b expected=%b at %0t",
                         in_reset ? "R10" : "R5", cfg_err, exp_err, $time);
            end
        end
    end

    // Drive one clock; gap inserts idle clocks after an enabled slot
    task automatic step(input bit en, input int gap);
        @(negedge clk);
        bit_en = en;
        tx_in = $urandom_range(0, 1);
        frm_slot = en && (slot_cnt % 193 == 0);
        if (en) slot_cnt++;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            bit_en = 1'b0;
            frm_slot = 1'b0;
            tx_in = $urandom_range(0, 1);
        end
    endtask

    task automatic run(input bit up, input bit dn, input int n, input int gap);
        @(negedge clk);
        loop_up_en = up;
        loop_dn_en = dn;
        bit_en = 1'b0;
        frm_slot = 1'b0;
        for (int i = 0; i < n; i++) step(1'b1, (gap > 0) ? (i % (gap + 1)) : 0);
    endtask

    // Stimulus: idle, both patterns, switches and the illegal state
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run(0, 0, 250, 0);   // R4
        run(1, 0, 600, 2);   // R1, R7, R8
        run(0, 0, 20, 0);    // R4 return to pass-through
        run(0, 1, 500, 0);   // R2, R7
        run(1, 0, 30, 1);    // R8 switch
        run(0, 1, 30, 0);    // R8 switch back
        run(1, 1, 60, 1);    // R5, R6
        run(1, 0, 400, 0);   // R8 after illegal
        run(0, 1, 7, 0);
        run(1, 1, 3, 0);
        run(0, 1, 300, 3);
        @(negedge clk);
        loop_up_en = 1'b0; loop_dn_en = 1'b0; bit_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;        // R10 mid-run reset
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run(1, 0, 200, 0);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule